// File: doc/BRIEF.md
# Multiplexed GPIO Bank with Input Glitch Filters

This block controls a bank of digital pins. Each pin is handed to one of four sources. The first source is the general-purpose data path. The other three are alternate peripheral functions. The selected source drives the pad output value and the pad output enable. Software keeps a small configuration word per pin: the source select, the general-purpose output enable, a pull request and a filter enable. The pull request is only passed out to the pad logic. The block never applies it itself.

Output data is written in one of two ways. A single-pin path changes one bit. A port path writes a whole 16-bit port at once. Both paths can fire in the same cycle. Reads always return the live pad level, whatever the pin is doing.

Pins named in a build-time mask carry a digital glitch filter. When the filter is on, a new input level is accepted only after it has held for a programmable number of sample ticks. A shared prescaler sets the tick rate. The filtered level feeds the selected peripheral input and a filtered port read.

Top module: `gpio_mux_bank`

## Requirements
- R1: While reset is held and right after it is released, every pad output enable is 0, every pad output value is 0 and both pull outputs are 0. A pin configuration reads 0. The global filter word reads with stable count 1 and prescale 0 (value 0x0001).
- R2: A pin with source select 00 drives its pad output from its general-purpose data bit. Its pad output enable comes from configuration bit 2. The per-pin configuration word uses these bits: [1:0] source, [2] output enable, [4:3] pull, [5] filter enable.
- R3: Source select 01, 10 and 11 route alternate slot 0, 1 and 2, at bit slot*NUM_PINS+pin, to that pin's pad output and output enable. The pin's filtered input is then copied to the same bit of the alternate input vector. The other two slots of that pin read 0.
- R4: A per-pin write changes that pin's data bit only, and the change is visible on the pad from the next clock cycle.
- R5: A port write replaces the 16 data bits of port p (pins 16p to 16p+15), visible from the next cycle.
- R6: When a per-pin write and a port write land in the same cycle on the same pin, that pin takes the per-pin value. The remaining bits of the port take the port value, and a per-pin write into another port also takes effect.
- R7: The pin read and both raw port reads return the current pad input level combinationally, independent of source select and output enable.
- R8: Pull field 10 asserts the pin's pull-up output and 01 asserts its pull-down output. Codes 00 and 11 assert neither.
- R9: With its filter on, a filtered pin changes its filtered level only after the new pad level has been seen on L consecutive sample ticks. A pulse seen on fewer ticks is dropped. L is global word bits [4:0].
- R10: Sample ticks occur once every (P+1) clock cycles, where P is global word bits [15:8].
- R11: Writing a stable count of 0 stores 1. Count 1 accepts a new level on the first tick.
- R12: On a pin outside the filter mask, the filter enable bit is ignored: it reads back 0 and the filtered level equals the pad level at once.
- R13: With its filter off, a filtered pin's filtered level follows the pad level combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_PINS+1) | Pin index, or NUM_PINS for the global filter word |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for cfg_addr |
| pin_we | input | 1 | Single-pin data write strobe |
| pin_sel | input | $clog2(NUM_PINS) | Pin addressed by the single-pin path |
| pin_wval | input | 1 | Value for the single-pin write |
| pin_rval | output | 1 | Live pad level of pin_sel |
| port_we | input | 1 | Port data write strobe |
| port_sel | input | max(1,$clog2(NUM_PINS/PORT_W)) | Port addressed by the port path |
| port_wval | input | PORT_W | Data for the port write |
| port_rval | output | PORT_W | Live pad levels of port_sel |
| port_fval | output | PORT_W | Filtered levels of port_sel |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pull_up_en | output | NUM_PINS | Pull-up requests to pad logic |
| pull_dn_en | output | NUM_PINS | Pull-down requests to pad logic |
| alt_out | input | 3*NUM_PINS | Output values from the three alternate functions |
| alt_oe | input | 3*NUM_PINS | Output enables from the three alternate functions |
| alt_in | output | 3*NUM_PINS | Inputs delivered to the three alternate functions |

## Verification
The bench builds the bank with 32 pins in two 16-bit ports and a filter mask of 0x000000FF. This gives two ports, so a port write and a per-pin write can land in the same port or in different ports. It also puts pins inside and outside the filter mask side by side. With pin 2 filtered and pin 20 unfiltered, the ignored filter enable can be watched at the ports. The default 5-bit count and 8-bit prescale let a count of 4 be checked at tick rate 1, and a count of 2 be checked at a prescale of 3, where the tick phase is unknown but bounded.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

   typedef enum logic [1:0] {
      SRC_GPIO = 2'b00,
      SRC_ALT1 = 2'b01,
      SRC_ALT2 = 2'b10,
      SRC_ALT3 = 2'b11
   } src_sel_e;

   typedef enum logic [1:0] {
      PULL_NONE = 2'b00,
      PULL_DN   = 2'b01,
      PULL_UP   = 2'b10,
      PULL_RSVD = 2'b11
   } pull_e;

   // packed layout: [5] filt_en, [4:3] pull, [2] gpio_oe, [1:0] src
   typedef struct packed {
      logic     filt_en;
      pull_e    pull;
      logic     gpio_oe;
      src_sel_e src;
   } pin_cfg_t;

   localparam int CFG_BITS = $bits(pin_cfg_t);
   localparam int NUM_ALT  = 3;
   localparam int CFG_DW   = 16;
   localparam int PRE_LSB  = 8;

endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic [LEN_W-1:0] len,
   input  logic             din,
   output logic             dout
);

   logic             q;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] last_cnt;

   assign last_cnt = len - LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= 1'b0;
         cnt <= '0;
      end else if (!en) begin
         q   <= din;
         cnt <= '0;
      end else if (tick) begin
         if (din == q) begin
            cnt <= '0;
         end else if (cnt >= last_cnt) begin
            q   <= din;
            cnt <= '0;
         end else begin
            cnt <= cnt + LEN_W'(1);
         end
      end
   end

   assign dout = en ? q : din;

endmodule

// File: rtl/gpio_sample_tick.sv
module gpio_sample_tick #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);

   logic [PRE_W-1:0] pcnt;

   assign tick = (pcnt >= pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (tick)    pcnt <= '0;
      else              pcnt <= pcnt + PRE_W'(1);
   end

endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs #(
   parameter int NUM_PINS = 32,
   parameter int PORT_W   = 16,
   parameter int PIN_IW   = 5,
   parameter int PORT_IW  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_we,
   input  logic [PIN_IW-1:0]   pin_sel,
   input  logic                pin_wval,
   input  logic                port_we,
   input  logic [PORT_IW-1:0]  port_sel,
   input  logic [PORT_W-1:0]   port_wval,
   output logic [NUM_PINS-1:0] dout_q
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      localparam int PIDX = i / PORT_W;
      localparam int BIDX = i % PORT_W;
      logic pin_hit, port_hit;
      assign pin_hit  = pin_we  && (pin_sel  == PIN_IW'(i));
      assign port_hit = port_we && (port_sel == PORT_IW'(PIDX));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dout_q[i] <= 1'b0;
         else if (pin_hit)  dout_q[i] <= pin_wval;
         else if (port_hit) dout_q[i] <= port_wval[BIDX];
      end
   end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_mux_pkg::*;
#(
   parameter int                  NUM_PINS  = 32,
   parameter logic [NUM_PINS-1:0] FILT_MASK = '1,
   parameter int                  LEN_W     = 5,
   parameter int                  PRE_W     = 8,
   parameter int                  CFG_AW    = 6,
   parameter int                  PIN_IW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   output pin_cfg_t          pin_cfg [NUM_PINS],
   output logic [LEN_W-1:0]  filt_len,
   output logic [PRE_W-1:0]  filt_pre,
   output logic              glb_wr
);

   localparam logic [CFG_AW-1:0] GLB_ADDR = CFG_AW'(NUM_PINS);

   pin_cfg_t         wcfg;
   logic [LEN_W-1:0] wlen;
   logic             unused_wbits;

   assign wcfg         = pin_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
   assign wlen         = cfg_wdata[LEN_W-1:0];
   assign glb_wr       = cfg_we && (cfg_addr == GLB_ADDR);
   assign unused_wbits = ^cfg_wdata;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic     hit;
      pin_cfg_t nxt;
      assign hit = cfg_we && (cfg_addr == CFG_AW'(i));
      always_comb begin
         nxt         = wcfg;
         nxt.filt_en = wcfg.filt_en & FILT_MASK[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   pin_cfg[i] <= '0;
         else if (hit) pin_cfg[i] <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_len <= LEN_W'(1);
         filt_pre <= '0;
      end else if (glb_wr) begin
         filt_len <= (wlen == '0) ? LEN_W'(1) : wlen;
         filt_pre <= cfg_wdata[PRE_LSB +: PRE_W];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == GLB_ADDR) begin
         cfg_rdata[LEN_W-1:0]         = filt_len;
         cfg_rdata[PRE_LSB +: PRE_W]  = filt_pre;
      end else if (cfg_addr < GLB_ADDR) begin
         cfg_rdata[CFG_BITS-1:0] = pin_cfg[cfg_addr[PIN_IW-1:0]];
      end
   end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
   import gpio_mux_pkg::*;
#(
   parameter int                  NUM_PINS  = 32,
   parameter int                  PORT_W    = 16,
   parameter int                  LEN_W     = 5,
   parameter int                  PRE_W     = 8,
   parameter logic [NUM_PINS-1:0] FILT_MASK = {{(NUM_PINS-NUM_PINS/2){1'b0}}, {(NUM_PINS/2){1'b1}}},
   localparam int NUM_PORTS = NUM_PINS / PORT_W,
   localparam int PIN_IW    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int PORT_IW   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int CFG_AW    = $clog2(NUM_PINS + 1),
   localparam int ALT_W     = NUM_ALT * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [CFG_DW-1:0]   cfg_wdata,
   output logic [CFG_DW-1:0]   cfg_rdata,
   input  logic                pin_we,
   input  logic [PIN_IW-1:0]   pin_sel,
   input  logic                pin_wval,
   output logic                pin_rval,
   input  logic                port_we,
   input  logic [PORT_IW-1:0]  port_sel,
   input  logic [PORT_W-1:0]   port_wval,
   output logic [PORT_W-1:0]   port_rval,
   output logic [PORT_W-1:0]   port_fval,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pull_up_en,
   output logic [NUM_PINS-1:0] pull_dn_en,
   input  logic [ALT_W-1:0]    alt_out,
   input  logic [ALT_W-1:0]    alt_oe,
   output logic [ALT_W-1:0]    alt_in
);

   // elaboration-time parameter checks
   if (PORT_W < 1 || PORT_W > CFG_DW) begin : g_bad_port_w
      $error("PORT_W must lie in 1..16");
   end
   if (NUM_PINS % PORT_W != 0) begin : g_bad_pins
      $error("NUM_PINS must be a whole number of ports");
   end
   if (LEN_W < 1 || LEN_W > PRE_LSB) begin : g_bad_len_w
      $error("LEN_W must lie in 1..8");
   end
   if (PRE_W < 1 || PRE_W > CFG_DW - PRE_LSB) begin : g_bad_pre_w
      $error("PRE_W must lie in 1..8");
   end

   pin_cfg_t              pin_cfg [NUM_PINS];
   logic [LEN_W-1:0]      filt_len;
   logic [PRE_W-1:0]      filt_pre;
   logic                  glb_wr;
   logic                  filt_tick;
   logic [NUM_PINS-1:0]   dout_q;
   logic [NUM_PINS-1:0]   filt_val;
   logic [NUM_PINS-1:0]   filt_en_vec;

   gpio_cfg_regs #(
      .NUM_PINS (NUM_PINS),
      .FILT_MASK(FILT_MASK),
      .LEN_W    (LEN_W),
      .PRE_W    (PRE_W),
      .CFG_AW   (CFG_AW),
      .PIN_IW   (PIN_IW)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .pin_cfg  (pin_cfg),
      .filt_len (filt_len),
      .filt_pre (filt_pre),
      .glb_wr   (glb_wr)
   );

   gpio_data_regs #(
      .NUM_PINS(NUM_PINS),
      .PORT_W  (PORT_W),
      .PIN_IW  (PIN_IW),
      .PORT_IW (PORT_IW)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_we   (pin_we),
      .pin_sel  (pin_sel),
      .pin_wval (pin_wval),
      .port_we  (port_we),
      .port_sel (port_sel),
      .port_wval(port_wval),
      .dout_q   (dout_q)
   );

   gpio_sample_tick #(.PRE_W(PRE_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(glb_wr),
      .pre    (filt_pre),
      .tick   (filt_tick)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic po, poe;

      always_comb begin
         po  = dout_q[i];
         poe = pin_cfg[i].gpio_oe;
         for (int k = 0; k < NUM_ALT; k++) begin
            if (pin_cfg[i].src == src_sel_e'(2'(k + 1))) begin
               po  = alt_out[k*NUM_PINS + i];
               poe = alt_oe[k*NUM_PINS + i];
            end
         end
      end

      assign pad_out[i]     = po;
      assign pad_oe[i]      = poe;
      assign pull_up_en[i]  = (pin_cfg[i].pull == PULL_UP);
      assign pull_dn_en[i]  = (pin_cfg[i].pull == PULL_DN);
      assign filt_en_vec[i] = pin_cfg[i].filt_en;

      for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
         assign alt_in[k*NUM_PINS + i] =
            (pin_cfg[i].src == src_sel_e'(2'(k + 1))) & filt_val[i];
      end

      if (FILT_MASK[i]) begin : g_filt
         gpio_glitch_filter #(.LEN_W(LEN_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (filt_tick),
            .en   (pin_cfg[i].filt_en),
            .len  (filt_len),
            .din  (pad_in[i]),
            .dout (filt_val[i])
         );
      end else begin : g_raw
         assign filt_val[i] = pad_in[i];
      end
   end

   assign pin_rval  = pad_in[pin_sel];
   assign port_rval = pad_in[port_sel*PORT_W +: PORT_W];
   assign port_fval = filt_val[port_sel*PORT_W +: PORT_W];

endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
   parameter int                  NUM_PINS  = 32,
   parameter int                  PORT_W    = 16,
   parameter int                  PIN_IW    = 5,
   parameter int                  PORT_IW   = 1,
   parameter int                  LEN_W     = 5,
   parameter int                  PRE_W     = 8,
   parameter logic [NUM_PINS-1:0] FILT_MASK = '1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                pin_we,
   input logic [PIN_IW-1:0]   pin_sel,
   input logic                pin_wval,
   input logic                port_we,
   input logic [PORT_IW-1:0]  port_sel,
   input logic [PORT_W-1:0]   port_wval,
   input logic [NUM_PINS-1:0] dout_q,
   input logic [NUM_PINS-1:0] filt_val,
   input logic [NUM_PINS-1:0] filt_en_vec,
   input logic                filt_tick,
   input logic [LEN_W-1:0]    filt_len,
   input logic [PRE_W-1:0]    filt_pre
);

   logic               l_pin_we, l_pin_wval, l_port_we;
   logic [PIN_IW-1:0]  l_pin_sel;
   logic [PORT_IW-1:0] l_port_sel;
   logic [PORT_W-1:0]  l_port_wval;
   logic               same_port;
   logic [PORT_W-1:0]  keep_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_pin_we    <= 1'b0;
         l_pin_wval  <= 1'b0;
         l_pin_sel   <= '0;
         l_port_we   <= 1'b0;
         l_port_sel  <= '0;
         l_port_wval <= '0;
      end else begin
         l_pin_we    <= pin_we;
         l_pin_wval  <= pin_wval;
         l_pin_sel   <= pin_sel;
         l_port_we   <= port_we;
         l_port_sel  <= port_sel;
         l_port_wval <= port_wval;
      end
   end

   assign same_port = ((int'(l_pin_sel) / PORT_W) == int'(l_port_sel));

   always_comb begin
      keep_mask = '1;
      if (l_pin_we && same_port) keep_mask[int'(l_pin_sel) % PORT_W] = 1'b0;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> pad_oe == '0);

   p_pin_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      l_pin_we |-> dout_q[l_pin_sel] == l_pin_wval);

   p_port_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      l_port_we |-> (dout_q[l_port_sel*PORT_W +: PORT_W] & keep_mask) == (l_port_wval & keep_mask));

   p_pin_over_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_pin_we && l_port_we && same_port) |-> dout_q[l_pin_sel] == l_pin_wval);

   p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_tick && filt_pre != '0) |=> (!filt_tick || filt_pre == '0));

   p_len_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      filt_len != '0);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_filt_chk
      if (FILT_MASK[i]) begin : g_on
         p_change_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_en_vec[i] && $past(filt_en_vec[i]) && !$stable(filt_val[i])) |-> $past(filt_tick));
      end
   end

endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .PORT_W   (PORT_W),
   .PIN_IW   (PIN_IW),
   .PORT_IW  (PORT_IW),
   .LEN_W    (LEN_W),
   .PRE_W    (PRE_W),
   .FILT_MASK(FILT_MASK)
) u_chk (.*);

// File: tb/gpio_mux_bank_test.sv
module gpio_mux_bank_test;

   localparam int          N  = 32;
   localparam int          PW = 16;
   localparam logic [31:0] FM = 32'h0000_00FF;
   localparam logic [5:0]  GLB = 6'd32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic [15:0]   cfg_rdata;
   logic          pin_we = 1'b0;
   logic [4:0]    pin_sel = '0;
   logic          pin_wval = 1'b0;
   logic          pin_rval;
   logic          port_we = 1'b0;
   logic [0:0]    port_sel = '0;
   logic [PW-1:0] port_wval = '0;
   logic [PW-1:0] port_rval, port_fval;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe, pull_up_en, pull_dn_en;
   logic [3*N-1:0] alt_out = '0;
   logic [3*N-1:0] alt_oe = '0;
   logic [3*N-1:0] alt_in;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   gpio_mux_bank #(
      .NUM_PINS(N), .PORT_W(PW), .LEN_W(5), .PRE_W(8), .FILT_MASK(FM)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pin_we(pin_we), .pin_sel(pin_sel), .pin_wval(pin_wval), .pin_rval(pin_rval),
      .port_we(port_we), .port_sel(port_sel), .port_wval(port_wval),
      .port_rval(port_rval), .port_fval(port_fval),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
   );

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic cfg_wr(input logic [5:0] a, input logic [15:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic pin_cfg(input int pin, input logic [1:0] src, input logic oe,
                          input logic [1:0] pull, input logic fen);
      cfg_wr(6'(pin), {10'b0, fen, pull, oe, src});
   endtask

   task automatic cfg_rd(input logic [5:0] a, output logic [15:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1", "oe in reset", pad_oe, '0);
      rst_n = 1'b1;
      step(1);
      check("R1", "oe after reset", pad_oe, '0);
      check("R1", "pad_out after reset", pad_out, '0);
      check("R1", "pulls after reset", {pull_up_en, pull_dn_en}, '0);
      cfg_rd(6'd5, d);
      check("R1", "pin cfg reset", d, 16'h0000);
      cfg_rd(GLB, d);
      check("R1", "global reset", d, 16'h0001);
   endtask

   task automatic t_gpio_out();
      pin_cfg(3, 2'b00, 1'b1, 2'b00, 1'b0);
      check("R2", "oe bit", pad_oe, 32'h0000_0008);
      pin_sel = 5'd3; pin_wval = 1'b1; pin_we = 1'b1;
      step(1);
      pin_we = 1'b0;
      check("R4", "pin write", pad_out, 32'h0000_0008);
   endtask

   task automatic t_port();
      port_sel = 1'b1; port_wval = 16'hA5C3; port_we = 1'b1;
      step(1);
      port_we = 1'b0;
      check("R5", "port1 write", pad_out, 32'hA5C3_0008);
   endtask

   task automatic t_collide();
      port_sel = 1'b0; port_wval = 16'h00F0; port_we = 1'b1;
      pin_sel = 5'd5; pin_wval = 1'b0; pin_we = 1'b1;
      step(1);
      check("R6", "same pin collision", pad_out, 32'hA5C3_00D0);
      port_wval = 16'hFFFF; pin_sel = 5'd20; pin_wval = 1'b1;
      step(1);
      port_we = 1'b0; pin_we = 1'b0;
      check("R6", "different port", pad_out, 32'hA5D3_FFFF);
   endtask

   task automatic t_altfunc();
      pad_in = 32'h0000_0200;
      alt_out[1*N + 9] = 1'b1; alt_oe[1*N + 9] = 1'b1;
      pin_cfg(9, 2'b10, 1'b0, 2'b00, 1'b0);
      check("R3", "alt2 out", pad_out[9], 1'b1);
      check("R3", "alt2 oe", pad_oe[9], 1'b1);
      check("R3", "alt_in slot", alt_in, 96'b1 << (1*N + 9));
      alt_out[1*N + 9] = 1'b0; alt_out[9] = 1'b1;
      #1;
      check("R3", "other slot ignored", pad_out[9], 1'b0);
      pin_cfg(9, 2'b01, 1'b0, 2'b00, 1'b0);
      check("R3", "alt1 out", pad_out[9], 1'b1);
      check("R3", "alt1 in", alt_in, 96'b1 << 9);
      pin_cfg(9, 2'b00, 1'b0, 2'b00, 1'b0);
      alt_out = '0; alt_oe = '0;
      check("R2", "back to gpio", pad_out[9], 1'b1);
   endtask

   task automatic t_readback();
      pad_in = 32'h1234_8001;
      pin_sel = 5'd15; port_sel = 1'b1;
      #1;
      check("R7", "pin15 raw", pin_rval, 1'b1);
      check("R7", "port1 raw", port_rval, 16'h1234);
      pin_sel = 5'd3; port_sel = 1'b0;
      #1;
      check("R7", "driven pin reads pad", pin_rval, 1'b0);
      check("R7", "port0 raw", port_rval, 16'h8001);
      pad_in = '0;
   endtask

   task automatic t_pull();
      pin_cfg(12, 2'b00, 1'b0, 2'b10, 1'b0);
      pin_cfg(13, 2'b00, 1'b0, 2'b01, 1'b0);
      check("R8", "pull up", pull_up_en, 32'h0000_1000);
      check("R8", "pull down", pull_dn_en, 32'h0000_2000);
      pin_cfg(12, 2'b00, 1'b0, 2'b11, 1'b0);
      check("R8", "code 11 none", {pull_up_en, pull_dn_en}, {32'h0, 32'h0000_2000});
   endtask

   task automatic t_filter();
      cfg_wr(GLB, 16'h0004);
      pin_cfg(2, 2'b00, 1'b0, 2'b00, 1'b1);
      step(2);
      port_sel = 1'b0;
      pad_in[2] = 1'b1;
      step(3);
      check("R9", "held 3 ticks", port_fval[2], 1'b0);
      step(1);
      check("R9", "held 4 ticks", port_fval[2], 1'b1);
      pad_in[2] = 1'b0;
      step(3);
      pad_in[2] = 1'b1;
      step(6);
      check("R9", "short pulse dropped", port_fval[2], 1'b1);
      pin_cfg(2, 2'b00, 1'b0, 2'b00, 1'b0);
      pad_in[2] = 1'b0;
      #1;
      check("R13", "filter off follows", port_fval[2], 1'b0);
   endtask

   task automatic t_prescale();
      cfg_wr(GLB, 16'h0302);
      pin_cfg(2, 2'b00, 1'b0, 2'b00, 1'b1);
      step(3);
      pad_in[2] = 1'b1;
      step(4);
      check("R10", "one tick in 4 cycles", port_fval[2], 1'b0);
      step(4);
      check("R10", "two ticks in 8 cycles", port_fval[2], 1'b1);
   endtask

   task automatic t_len_zero();
      logic [15:0] d;
      cfg_wr(GLB, 16'h0000);
      cfg_rd(GLB, d);
      check("R11", "zero stored as one", d, 16'h0001);
      pad_in[2] = 1'b0;
      #1;
      check("R11", "still registered", port_fval[2], 1'b1);
      step(1);
      check("R11", "accept on first tick", port_fval[2], 1'b0);
   endtask

   task automatic t_nofilt();
      logic [15:0] d;
      pin_cfg(20, 2'b00, 1'b0, 2'b00, 1'b1);
      cfg_rd(6'd20, d);
      check("R12", "enable reads 0", d, 16'h0000);
      port_sel = 1'b1;
      pad_in[20] = 1'b1;
      #1;
      check("R12", "unmasked rises", port_fval[4], 1'b1);
      pad_in[20] = 1'b0;
      #1;
      check("R12", "unmasked falls", port_fval[4], 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      step(3);
      t_reset();
      t_gpio_out();
      t_port();
      t_collide();
      t_altfunc();
      t_readback();
      t_pull();
      t_filter();
      t_prescale();
      t_len_zero();
      t_nofilt();
      step(2);
      report();
      $finish;
   end

endmodule